// File: doc/BRIEF.md
# Buffered SPI Memory Transaction Engine

This block runs one complete single-lane SPI transaction against a serial memory device, staging every byte in a small internal byte RAM. Software fills the start of the buffer with the bytes to send: opcode, address, dummy bytes and any write payload. It then sets an output byte count and an input byte count, and fires the engine with an enable-then-trigger sequence on the control register.

The engine drops chip select and shifts the output bytes out in SPI mode 0, with the serial clock running at half the system clock. It then clocks in the requested input bytes and stores each one in the buffer directly behind the last output byte. It raises chip select, holds it high for a programmable deselect time, and clears its work-in-progress flag. Software reads the response out of the buffer and writes the control register to zero to return the engine to idle.

A soft-reset bit abandons any transaction in flight. A status field shows the engine state, and it reads zero only when the engine is idle.

Top module: `spi_xact_engine`

## Requirements
- R1: After reset, chip select is high and the serial clock is low. The control register and the status register read 0. The misc register reads 0x0400000A: deselect count 10 in bits 4:0 and read-latch latency 2 in bits 26:25.
- R2: The register space is addressed by word. Word 0 is control, word 1 the output count, word 2 the input count, word 3 misc and word 4 status. Words 32 to 63 map the buffer. In the control register, bit 3 is enable, bit 2 is trigger, bit 1 is ready and bit 0 is busy. The trigger bit always reads 0. A control write with bits 3 and 2 both set, made while the engine is idle, starts a transaction and sets both ready and busy.
- R3: During a transaction chip select is low. The output bytes are sent in order of ascending buffer offset, starting at offset 0, and each byte is sent MSB first. Buffer byte k of a word sits in bits 8k+7:8k. The serial clock is low whenever chip select is high, and MOSI holds steady while the serial clock is high.
- R4: Input byte i is stored at buffer offset (output count + i). Output bytes in the buffer are left unchanged.
- R5: Busy clears only after the transaction ends and chip select has returned high. Ready stays 1 until a control write with bit 3 clear, which returns the engine to idle: status 0, ready 0.
- R6: If the output count plus the input count exceeds 128, the trigger is ignored. The engine stays idle and chip select stays high. A sum of exactly 128 runs normally.
- R7: An output count of 0 or an input count of 0 skips that phase. If both counts are 0, the engine completes without lowering chip select.
- R8: Writes to the buffer and to the two count registers are ignored from the trigger until busy clears.
- R9: A misc write with bit 28 set forces the engine to idle at once. Chip select goes high, and ready, busy and the status field (bits 3:0) clear. The status field is nonzero while a transaction is active.
- R10: After chip select rises, busy stays set for more cycles than the deselect count. Misc writes update both misc fields, and the fields read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address of register or buffer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the address |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench targets input placement at an unaligned output count (5). A design that stored input from offset 0 or from a word boundary would overwrite the command bytes or put the response in the wrong lane. It probes the 128-byte boundary from both sides, with sums of 128 and 129. A wrong comparator would either reject a legal transaction or run an oversized one. Writes made mid-transaction must not alter the bytes still queued for output. A soft reset must drop chip select mid-stream. The time from chip-select rise to busy clear is measured against a large deselect count, which exposes a design that skipped the deselect wait.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  // Register word indices (low three address bits, buffer bit clear)
  localparam logic [2:0] RX_CTRL   = 3'd0;
  localparam logic [2:0] RX_OUTCNT = 3'd1;
  localparam logic [2:0] RX_INCNT  = 3'd2;
  localparam logic [2:0] RX_MISC   = 3'd3;
  localparam logic [2:0] RX_STATUS = 3'd4;

  localparam logic [4:0] DESEL_RESET = 5'd10;
  localparam logic [1:0] LATCH_RESET = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_FETCH = 4'd1,
    ST_LOAD  = 4'd2,
    ST_OUTB  = 4'd3,
    ST_INB   = 4'd4,
    ST_STORE = 4'd5,
    ST_DESEL = 4'd6,
    ST_DONE  = 4'd7
  } xstate_t;

endpackage

// File: rtl/spi_xact_buf.sv
module spi_xact_buf #(
  parameter int WORDS = 32,
  parameter int WA_W  = 5
) (
  input  logic            clk,
  input  logic            we,
  input  logic [3:0]      be,
  input  logic [WA_W-1:0] waddr,
  input  logic [31:0]     wdata,
  input  logic [WA_W-1:0] raddr_a,
  output logic [31:0]     qa,
  input  logic [WA_W-1:0] raddr_b,
  output logic [31:0]     qb
);

  // One byte-wide RAM per lane: one write port, two synchronous read ports
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] qa_l, qb_l;

    always_ff @(posedge clk) begin
      if (we && be[g]) mem[waddr] <= wdata[8*g +: 8];
      qa_l <= mem[raddr_a];
      qb_l <= mem[raddr_b];
    end

    assign qa[8*g +: 8] = qa_l;
    assign qb[8*g +: 8] = qb_l;
  end

endmodule

// File: rtl/spi_xact_ctrl.sv
module spi_xact_ctrl
  import spi_xact_pkg::*;
#(
  parameter int BUF_BYTES = 128
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            reg_we,
  input  logic [$clog2(BUF_BYTES)-2:0]    reg_addr,
  input  logic [31:0]                     reg_wdata,
  output logic [31:0]                     reg_rdata,
  output logic                            spi_cs_n,
  output logic                            spi_sck,
  output logic                            spi_mosi,
  input  logic                            spi_miso,
  output logic                            buf_we,
  output logic [3:0]                      buf_be,
  output logic [$clog2(BUF_BYTES)-3:0]    buf_waddr,
  output logic [31:0]                     buf_wdata,
  output logic [$clog2(BUF_BYTES)-3:0]    buf_raddr_a,
  input  logic [31:0]                     buf_qa,
  output logic [$clog2(BUF_BYTES)-3:0]    buf_raddr_b,
  input  logic [31:0]                     buf_qb
);

  localparam int BA_W  = $clog2(BUF_BYTES);
  localparam int WA_W  = BA_W - 2;
  localparam int AW    = WA_W + 1;
  localparam int LEN_W = BA_W + 1;
  localparam logic [LEN_W-1:0] ONE   = 1;
  localparam logic [LEN_W:0]   LIMIT = (LEN_W+1)'(BUF_BYTES);

  xstate_t          state;
  logic             en_q, ready_q, wip_q;
  logic [LEN_W-1:0] out_len, in_len, idx;
  logic [4:0]       desel_cfg, dc;
  logic [1:0]       latch_cfg;
  logic [2:0]       bc;
  logic             ph, sck_q, cs_n_q;
  logic [7:0]       sr;
  logic             sel_buf_q;
  logic [31:0]      regs_q;

  // Address decode
  logic            is_buf;
  logic [2:0]      rsel;
  logic            busy, ctrl_wr, misc_wr, soft_rst, start;
  logic [LEN_W:0]  total;
  logic [BA_W-1:0] eng_byte;

  assign is_buf   = reg_addr[AW-1];
  assign rsel     = reg_addr[2:0];
  assign busy     = (state != ST_IDLE) && (state != ST_DONE);
  assign ctrl_wr  = reg_we && !is_buf && (rsel == RX_CTRL);
  assign misc_wr  = reg_we && !is_buf && (rsel == RX_MISC);
  assign soft_rst = misc_wr && reg_wdata[28];
  assign total    = {1'b0, out_len} + {1'b0, in_len};
  assign start    = (state == ST_IDLE) && ctrl_wr && reg_wdata[3] && reg_wdata[2] &&
                    (total <= LIMIT);
  assign eng_byte = (state == ST_STORE) ? (out_len[BA_W-1:0] + idx[BA_W-1:0]) : idx[BA_W-1:0];

  // Buffer port muxing: engine owns the write port only in STORE
  assign buf_raddr_a = reg_addr[WA_W-1:0];
  assign buf_raddr_b = eng_byte[BA_W-1:2];
  always_comb begin
    if (state == ST_STORE) begin
      buf_we    = 1'b1;
      buf_be    = 4'b0001 << eng_byte[1:0];
      buf_waddr = eng_byte[BA_W-1:2];
      buf_wdata = {4{sr}};
    end else begin
      buf_we    = reg_we && is_buf && !busy;
      buf_be    = 4'hF;
      buf_waddr = reg_addr[WA_W-1:0];
      buf_wdata = reg_wdata;
    end
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      out_len   <= '0;
      in_len    <= '0;
      desel_cfg <= DESEL_RESET;
      latch_cfg <= LATCH_RESET;
    end else if (reg_we && !is_buf) begin
      if (rsel == RX_CTRL) en_q <= reg_wdata[3];
      if (rsel == RX_OUTCNT && !busy) out_len <= reg_wdata[LEN_W-1:0];
      if (rsel == RX_INCNT && !busy)  in_len  <= reg_wdata[LEN_W-1:0];
      if (rsel == RX_MISC) begin
        desel_cfg <= reg_wdata[4:0];
        latch_cfg <= reg_wdata[26:25];
      end
    end
  end

  // Transaction sequencer
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state   <= ST_IDLE;
      ready_q <= 1'b0;
      wip_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      ph      <= 1'b0;
      bc      <= '0;
      idx     <= '0;
      sr      <= '0;
      dc      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          ready_q <= 1'b1;
          wip_q   <= 1'b1;
          idx     <= '0;
          bc      <= '0;
          ph      <= 1'b0;
          sr      <= '0;
          dc      <= '0;
          if (out_len != '0) begin
            cs_n_q <= 1'b0;
            state  <= ST_FETCH;
          end else if (in_len != '0) begin
            cs_n_q <= 1'b0;
            state  <= ST_INB;
          end else begin
            state  <= ST_DESEL;
          end
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          sr    <= buf_qb[{idx[1:0], 3'b000} +: 8];
          state <= ST_OUTB;
        end
        ST_OUTB: if (!ph) begin
          sck_q <= 1'b1;
          ph    <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          ph    <= 1'b0;
          sr    <= {sr[6:0], 1'b0};
          bc    <= bc + 3'd1;
          if (bc == 3'd7) begin
            if (idx + ONE == out_len) begin
              idx <= '0;
              if (in_len != '0) begin
                state <= ST_INB;
              end else begin
                cs_n_q <= 1'b1;
                dc     <= '0;
                state  <= ST_DESEL;
              end
            end else begin
              idx   <= idx + ONE;
              state <= ST_FETCH;
            end
          end
        end
        ST_INB: if (!ph) begin
          sck_q <= 1'b1;
          ph    <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          ph    <= 1'b0;
          sr    <= {sr[6:0], spi_miso};
          bc    <= bc + 3'd1;
          if (bc == 3'd7) state <= ST_STORE;
        end
        ST_STORE: if (idx + ONE == in_len) begin
          cs_n_q <= 1'b1;
          dc     <= '0;
          state  <= ST_DESEL;
        end else begin
          idx   <= idx + ONE;
          state <= ST_INB;
        end
        ST_DESEL: if (dc == desel_cfg) begin
          wip_q <= 1'b0;
          state <= ST_DONE;
        end else begin
          dc <= dc + 5'd1;
        end
        ST_DONE: if (ctrl_wr && !reg_wdata[3]) begin
          ready_q <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Register read path, one cycle latency
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_buf_q <= 1'b0;
      regs_q    <= '0;
    end else begin
      sel_buf_q <= is_buf;
      case (rsel)
        RX_CTRL:   regs_q <= {28'd0, en_q, 1'b0, ready_q, wip_q};
        RX_OUTCNT: regs_q <= 32'(out_len);
        RX_INCNT:  regs_q <= 32'(in_len);
        RX_MISC:   regs_q <= {5'd0, latch_cfg, 20'd0, desel_cfg};
        RX_STATUS: regs_q <= {28'd0, state};
        default:   regs_q <= '0;
      endcase
    end
  end

  assign reg_rdata = sel_buf_q ? buf_qa : regs_q;
  assign spi_cs_n  = cs_n_q;
  assign spi_sck   = sck_q;
  assign spi_mosi  = (state == ST_OUTB) & sr[7];

endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine #(
  parameter int BUF_BYTES = 128
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_we,
  input  logic [$clog2(BUF_BYTES)-2:0] reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  output logic                         spi_cs_n,
  output logic                         spi_sck,
  output logic                         spi_mosi,
  input  logic                         spi_miso
);

  localparam int WA_W  = $clog2(BUF_BYTES) - 2;
  localparam int WORDS = BUF_BYTES / 4;
  localparam int AW    = WA_W + 1;

  logic            buf_we;
  logic [3:0]      buf_be;
  logic [WA_W-1:0] buf_waddr, buf_raddr_a, buf_raddr_b;
  logic [31:0]     buf_wdata, buf_qa, buf_qb;

  spi_xact_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .buf_we(buf_we), .buf_be(buf_be), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr_a(buf_raddr_a), .buf_qa(buf_qa), .buf_raddr_b(buf_raddr_b), .buf_qb(buf_qb)
  );

  spi_xact_buf #(.WORDS(WORDS), .WA_W(WA_W)) u_buf (
    .clk(clk), .we(buf_we), .be(buf_be), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr_a(buf_raddr_a), .qa(buf_qa), .raddr_b(buf_raddr_b), .qb(buf_qb)
  );

endmodule

// File: rtl/spi_xact_chk.sv
module spi_xact_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          wd_srst,
  input logic [4:0]    wd_desel,
  input logic          spi_cs_n,
  input logic          spi_sck,
  input logic          spi_mosi
);

  localparam logic [AW-1:0] MISC_ADDR = AW'(3);

  logic       misc_wr;
  logic [5:0] hi_cnt;
  logic [4:0] cfg_sh, snap;

  assign misc_wr = reg_we && (reg_addr == MISC_ADDR);

  // Track consecutive chip-select-high cycles and the deselect setting
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= 6'd63;
      cfg_sh <= 5'd10;
      snap   <= 5'd0;
    end else begin
      if (misc_wr) cfg_sh <= wd_desel;
      if (!spi_cs_n) snap <= cfg_sh;
      if (!spi_cs_n)           hi_cnt <= '0;
      else if (hi_cnt != 6'd63) hi_cnt <= hi_cnt + 6'd1;
    end
  end

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);                                           // R3

  AST_MOSI_STABLE_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> $stable(spi_mosi));                                   // R3

  AST_SOFT_RESET_DESELECTS: assert property (@(posedge clk) disable iff (rst)
    (misc_wr && wd_srst) |=> spi_cs_n);                               // R9

  AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (hi_cnt > {1'b0, snap}));                     // R10

endmodule

bind spi_xact_engine spi_xact_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .wd_srst(reg_wdata[28]), .wd_desel(reg_wdata[4:0]),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/spi_xact_engine_test.sv
module spi_xact_engine_test;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          spi_cs_n, spi_sck, spi_mosi;
  logic          spi_miso = 1'b0;

  always #10 clk = ~clk;

  spi_xact_engine uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit summary_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Behavioural device model: records MOSI, serves MISO from resp[]
  logic [7:0] ob   [128];
  logic [7:0] resp [128];
  logic [7:0] got  [128];
  int exp_out  = 0;
  int sck_cnt  = 0;
  int sck_base = 0;
  int cs_falls = 0;
  int rise_cyc = 0;
  int viol     = 0;

  always @(posedge spi_sck) begin
    int k, j;
    k = sck_cnt - sck_base;
    if (k < exp_out * 8) begin
      got[k / 8] = {got[k / 8][6:0], spi_mosi};
    end else begin
      j = k - exp_out * 8;
      if (j < 1024) spi_miso = resp[(j / 8) % 128][7 - (j % 8)];
    end
    sck_cnt = sck_cnt + 1;
  end

  always @(negedge spi_cs_n) cs_falls = cs_falls + 1;
  always @(posedge spi_cs_n) rise_cyc = cyc;

  // Per-clock protocol comparison: a deselected device must see an idle-low clock
  always @(negedge clk) if (!rst && spi_cs_n && spi_sck) viol = viol + 1;

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_byte(input int b, output logic [7:0] v);
    logic [31:0] d;
    rd(32 + b / 4, d);
    v = d[8 * (b % 4) +: 8];
  endtask

  task automatic fill(input int seed);
    for (int b = 0; b < 128; b++) begin
      ob[b]   = 8'((b * 37 + seed * 11 + 5) & 255);
      resp[b] = 8'(((b * 91 + seed * 7 + 17) & 255) ^ 8'hA5);
    end
  endtask

  task automatic load_buf(input int n);
    for (int w = 0; w < (n + 3) / 4; w++)
      wr(32 + w, {ob[4*w+3], ob[4*w+2], ob[4*w+1], ob[4*w]});
  endtask

  task automatic trigger(input int o, input int i);
    exp_out  = o;
    sck_base = sck_cnt;
    wr(1, 32'(o));
    wr(2, 32'(i));
    wr(0, 32'h8);
    wr(0, 32'hC);
  endtask

  task automatic wait_done(input string req, output int done_cyc);
    logic [31:0] d;
    bit ok = 1'b0;
    done_cyc = 0;
    for (int n = 0; n < 20000 && !ok; n++) begin
      rd(0, d);
      if (!d[0]) begin ok = 1'b1; done_cyc = cyc; end
    end
    chk(req, "busy clears, ready held", d, 32'hA);
  endtask

  task automatic check_out(input int o, input string req);
    int bad = 0;
    for (int b = 0; b < o; b++) if (got[b] !== ob[b]) bad++;
    chk(req, "mosi byte stream mismatches", 32'(bad), 32'd0);
  endtask

  task automatic check_buf(input int o, input int i, input string req);
    logic [7:0] v;
    int bad_o = 0;
    int bad_i = 0;
    for (int b = 0; b < o; b++) begin rd_byte(b, v); if (v !== ob[b]) bad_o++; end
    for (int b = 0; b < i; b++) begin rd_byte(o + b, v); if (v !== resp[b]) bad_i++; end
    chk(req, "output region disturbed", 32'(bad_o), 32'd0);
    chk(req, "input bytes misplaced", 32'(bad_i), 32'd0);
  endtask

  task automatic back_to_idle(input string req);
    logic [31:0] d;
    wr(0, 32'h0);
    rd(0, d);
    chk(req, "ctrl after clear", d, 32'h0);
    rd(4, d);
    chk(req, "status after clear", d, 32'h0);
  endtask

  task automatic finish_run;
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int dc, falls0;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", "cs_n", 32'(spi_cs_n), 32'd1);
    chk("R1", "sck", 32'(spi_sck), 32'd0);
    rd(0, d); chk("R1", "ctrl", d, 32'h0);
    rd(4, d); chk("R1", "status", d, 32'h0);
    rd(3, d); chk("R1", "misc", d, 32'h0400000A);

    // R2/R3/R4/R5: 4 out, 3 in
    fill(1); load_buf(4);
    exp_out = 4; sck_base = sck_cnt;
    wr(1, 32'd4); wr(2, 32'd3);
    wr(0, 32'h8);
    rd(0, d); chk("R2", "enable only", d, 32'h8);
    wr(0, 32'hC);
    rd(0, d); chk("R2", "ready and busy after trigger", d, 32'hB);
    rd(4, d); chk("R9", "status nonzero while active", 32'(d[3:0] != 4'd0), 32'd1);
    wait_done("R5", dc);
    check_out(4, "R3");
    check_buf(4, 3, "R4");
    back_to_idle("R5");

    // R4 unaligned output count
    fill(2); load_buf(5);
    trigger(5, 6);
    wait_done("R5", dc);
    check_out(5, "R3");
    check_buf(5, 6, "R4");
    back_to_idle("R5");

    // R7 output only, input only, neither
    fill(3); load_buf(3);
    trigger(3, 0);
    wait_done("R7", dc);
    check_out(3, "R7");
    back_to_idle("R7");

    fill(4);
    trigger(0, 2);
    wait_done("R7", dc);
    check_buf(0, 2, "R7");
    back_to_idle("R7");

    falls0 = cs_falls;
    trigger(0, 0);
    wait_done("R7", dc);
    chk("R7", "chip select never lowered", 32'(cs_falls - falls0), 32'd0);
    back_to_idle("R7");

    // R6 length limit
    falls0 = cs_falls;
    trigger(100, 29);
    rd(0, d); chk("R6", "oversize trigger ignored", d, 32'h8);
    rd(4, d); chk("R6", "status idle", d, 32'h0);
    chk("R6", "no chip select", 32'(cs_falls - falls0), 32'd0);
    wr(0, 32'h0);
    fill(5); load_buf(100);
    trigger(100, 28);
    wait_done("R6", dc);
    check_out(100, "R6");
    check_buf(100, 28, "R6");
    back_to_idle("R6");

    // R8 writes ignored while busy
    fill(6); load_buf(8);
    trigger(8, 4);
    wr(32, 32'hDEADBEEF);
    wr(1, 32'd2);
    wait_done("R8", dc);
    check_out(8, "R8");
    rd(32, d); chk("R8", "buffer word 0 kept", d, {ob[3], ob[2], ob[1], ob[0]});
    rd(1, d); chk("R8", "output count kept", d, 32'd8);
    back_to_idle("R8");

    // R9 soft reset mid transaction
    fill(7); load_buf(16);
    trigger(16, 16);
    repeat (100) @(negedge clk);
    chk("R9", "cs low before soft reset", 32'(spi_cs_n), 32'd0);
    wr(3, 32'h1000_0000 | 32'h0400_0005);
    chk("R9", "cs high after soft reset", 32'(spi_cs_n), 32'd1);
    rd(4, d); chk("R9", "status idle", d, 32'h0);
    rd(0, d); chk("R9", "ready and busy cleared", {30'd0, d[1:0]}, 32'h0);
    rd(3, d); chk("R10", "misc readback", d, 32'h0400_0005);
    wr(0, 32'h0);

    // R10 deselect time before busy clears
    wr(3, 32'h0400_001F);
    fill(8); load_buf(2);
    trigger(2, 1);
    wait_done("R10", dc);
    chk("R10", "deselect wait observed", 32'((dc - rise_cyc) >= 31), 32'd1);
    check_buf(2, 1, "R4");
    back_to_idle("R10");

    chk("R3", "clock active while deselected", 32'(viol), 32'd0);

    finish_run();
  end

endmodule